// File: doc/BRIEF.md
# Collision-Vector Initiation Controller

This block guards the entry of a non-linear pipeline whose reservation pattern is fixed. It keeps a collision vector in a register and, on every clock, decides whether a waiting job may enter now without a structural clash with jobs already in flight. A requester raises `req` and holds it. The controller answers in the same cycle with `initiate` when the job is admitted, or with `stall` when that latency is forbidden. The requester keeps `req` high until it sees `initiate`.

The vector is written with its most significant bit on the left. Every clock the vector moves one place towards the MSB, the old MSB is discarded and a 0 enters at bit 0. The bit that decides admission is the MSB of that moved vector, which is bit `W-2` of the current state. When a job is admitted, the initial collision vector is ORed into the moved vector. The initial vector is supplied on a configuration input and captured while reset is asserted. An all-zero state means the pipeline is empty.

Top module: `cvInitCtrl`

## Requirements
- R1: While `rst` is high, `initiate` and `stall` are 0. On the first cycle after reset, `cvState` is all zeros.
- R2: `cfgIcv` is captured only while `rst` is high. A change to it after reset has no effect on any later state.
- R3: In a cycle with `req` low, the next `cvState` is the current one moved one place towards the MSB, with the MSB dropped and a 0 entering at bit 0.
- R4: In a cycle with `req` high and bit `W-2` of `cvState` equal to 0, `initiate` is 1 in that same cycle. The next state is the moved vector ORed with the captured initial vector.
- R5: In a cycle with `req` high and bit `W-2` of `cvState` equal to 1, `stall` is 1 and `initiate` is 0. The next state is the moved vector alone.
- R6: The all-zero state stays all-zero while no request arrives. A request in that state is always admitted, and the next state equals the captured initial vector.
- R7: `initiate` and `stall` are never both 1, and neither is 1 without `req`.
- R8: With initial vector 101001 and `W` = 6, two back-to-back requests from an empty pipeline give states 101001 and then 111011. A request held after that stalls twice and is admitted on the third cycle, giving 111001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; the initial vector is captured while it is high |
| req | input | 1 | Pending job request, held until admitted |
| cfgIcv | input | CV_WIDTH | Initial collision vector (MSB on the left) |
| initiate | output | 1 | Job admitted in this cycle |
| stall | output | 1 | Request present but its latency is forbidden |
| cvState | output | CV_WIDTH | Current collision vector |

## Verification
A wrong state bit shows up on `cvState` at the next falling-edge sample. If the bit sits at position `W-2`, it also flips `initiate` and `stall` in the cycle where a request meets it. A corrupted bit in a lower position moves one place towards the MSB each idle cycle, so it reaches the admission decision within at most `W-2` cycles. A bad captured initial vector only appears after the next admission, which is why the bench admits jobs in every phase. Because the bench compares the state every cycle against a behavioural queue model, an error is reported in the cycle it first appears.

// File: rtl/cvInitPkg.sv
package cvInitPkg;

  // Strobes from the admission control to the vector datapath
  typedef struct packed {
    logic admit;   // merge the initial vector into the moved state
    logic hold;    // request present but refused this cycle
  } ctrlStrobes_t;

endpackage

// File: rtl/cvInitCtrlFsm.sv
module cvInitCtrlFsm
  import cvInitPkg::*;
(
  input  logic         rst,
  input  logic         req,
  input  logic         latBlocked,
  output ctrlStrobes_t strobes,
  output logic         initiate,
  output logic         stall
);

  // Admission decision: free latency and a pending request
  always_comb begin
    strobes.admit = 1'b0;
    strobes.hold  = 1'b0;
    if (!rst && req) begin
      if (latBlocked) strobes.hold  = 1'b1;
      else            strobes.admit = 1'b1;
    end
  end

  assign initiate = strobes.admit;
  assign stall    = strobes.hold;

endmodule

// File: rtl/cvInitDatapath.sv
module cvInitDatapath
  import cvInitPkg::*;
#(
  parameter int CV_WIDTH = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CV_WIDTH-1:0] cfgIcv,
  input  ctrlStrobes_t        strobes,
  output logic                latBlocked,
  output logic [CV_WIDTH-1:0] cvState
);

  localparam int EXAM_IDX = CV_WIDTH - 2;

  logic [CV_WIDTH-1:0] icvQ;
  logic [CV_WIDTH-1:0] stateQ;
  logic [CV_WIDTH-1:0] movedVec;
  logic [CV_WIDTH-1:0] mergeVec;

  // Move towards the MSB: bit i takes bit i-1, a zero enters at bit 0
  always_comb begin
    movedVec[0] = 1'b0;
    for (int i = 1; i < CV_WIDTH; i++) movedVec[i] = stateQ[i-1];
  end

  assign mergeVec   = strobes.admit ? (movedVec | icvQ) : movedVec;
  assign latBlocked = stateQ[EXAM_IDX];

  always_ff @(posedge clk) begin
    if (rst) begin
      icvQ   <= cfgIcv;
      stateQ <= '0;
    end else begin
      stateQ <= mergeVec;
    end
  end

  assign cvState = stateQ;

endmodule

// File: rtl/cvInitCtrl.sv
module cvInitCtrl
  import cvInitPkg::*;
#(
  parameter int CV_WIDTH = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req,
  input  logic [CV_WIDTH-1:0] cfgIcv,
  output logic                initiate,
  output logic                stall,
  output logic [CV_WIDTH-1:0] cvState
);

  ctrlStrobes_t strobes;
  logic         latBlocked;

  cvInitCtrlFsm ctrl_i (
    .rst        (rst),
    .req        (req),
    .latBlocked (latBlocked),
    .strobes    (strobes),
    .initiate   (initiate),
    .stall      (stall)
  );

  cvInitDatapath #(.CV_WIDTH(CV_WIDTH)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .cfgIcv     (cfgIcv),
    .strobes    (strobes),
    .latBlocked (latBlocked),
    .cvState    (cvState)
  );

endmodule

// File: rtl/cvInitCtrlChk.sv
module cvInitCtrlChk #(
  parameter int CV_WIDTH = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                req,
  input logic [CV_WIDTH-1:0] cfgIcv,
  input logic                initiate,
  input logic                stall,
  input logic [CV_WIDTH-1:0] cvState
);

  logic [CV_WIDTH-1:0] icvChk;
  always_ff @(posedge clk) if (rst) icvChk <= cfgIcv;

  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    rst |-> (!initiate && !stall));

  assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cvState == '0));

  assert_idle_shift_R3: assert property (@(posedge clk) disable iff (rst)
    !req |=> (cvState == {$past(cvState[CV_WIDTH-2:0]), 1'b0}));

  assert_admit_merge_R4: assert property (@(posedge clk) disable iff (rst)
    initiate |=> (cvState == ({$past(cvState[CV_WIDTH-2:0]), 1'b0} | icvChk)));

  assert_stall_shift_R5: assert property (@(posedge clk) disable iff (rst)
    stall |=> (cvState == {$past(cvState[CV_WIDTH-2:0]), 1'b0}));

  assert_empty_accepts_R6: assert property (@(posedge clk) disable iff (rst)
    (req && cvState == '0) |-> initiate);

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(initiate && stall));

  assert_needs_req_R7: assert property (@(posedge clk) disable iff (rst)
    (initiate || stall) |-> req);

endmodule

bind cvInitCtrl cvInitCtrlChk #(.CV_WIDTH(CV_WIDTH)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .req      (req),
  .cfgIcv   (cfgIcv),
  .initiate (initiate),
  .stall    (stall),
  .cvState  (cvState)
);

// File: tb/cvInitCtrl_tb_top.sv
module cvInitCtrl_tb_top;

  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req = 1'b0;
  logic [W-1:0] cfgIcv = '0;
  logic         initiate;
  logic         stall;
  logic [W-1:0] cvState;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  bit mdl[$];       // index 0 = leftmost (MSB) position
  bit icvBits[$];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;   // 250 MHz

  cvInitCtrl #(.CV_WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .req(req), .cfgIcv(cfgIcv),
    .initiate(initiate), .stall(stall), .cvState(cvState)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mdlVec();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[W-1-i] = mdl[i];
    return v;
  endfunction

  task automatic doReset(input logic [W-1:0] icv);
    @(negedge clk);
    rst = 1'b1; cfgIcv = icv; req = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(initiate == 1'b0, "R1 initiate in reset", W'(initiate), '0);
      chk(stall == 1'b0, "R1 stall in reset", W'(stall), '0);
      @(negedge clk);
    end
    rst = 1'b0; req = 1'b0;
    mdl.delete(); icvBits.delete();
    for (int i = 0; i < W; i++) begin
      mdl.push_back(1'b0);
      icvBits.push_back(icv[W-1-i]);
    end
    chk(cvState == '0, "R1 state after reset", cvState, '0);
  endtask

  // Called at a falling edge: drive, compare outputs, advance, compare state
  task automatic step(input logic r, input string tag);
    bit expInit, expStall;
    req = r;
    #1;
    expInit  = r && !mdl[1];
    expStall = r && mdl[1];
    chk(initiate == expInit, {tag, " initiate (R4/R7)"}, W'(initiate), W'(expInit));
    chk(stall == expStall, {tag, " stall (R5/R7)"}, W'(stall), W'(expStall));
    @(posedge clk);
    void'(mdl.pop_front());
    mdl.push_back(1'b0);
    if (expInit) for (int i = 0; i < W; i++) mdl[i] = mdl[i] | icvBits[i];
    @(negedge clk);
    chk(cvState == mdlVec(), {tag, " state (R3)"}, cvState, mdlVec());
  endtask

  task automatic randomRun(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], tag);
    end
  endtask

  initial begin
    doReset(6'b101001);
    cfgIcv = 6'b010101;                      // R2: must be ignored
    for (int k = 0; k < 3; k++) step(1'b0, "R6 idle empty");
    chk(cvState == '0, "R6 empty holds", cvState, '0);
    step(1'b1, "R6 accept from empty");
    chk(cvState == 6'b101001, "R2 R8 first state", cvState, 6'b101001);
    step(1'b1, "R8 back-to-back");
    chk(cvState == 6'b111011, "R8 second state", cvState, 6'b111011);
    step(1'b1, "R5 held stall 1");
    step(1'b1, "R5 held stall 2");
    step(1'b1, "R8 admit third");
    chk(cvState == 6'b111001, "R8 third state", cvState, 6'b111001);
    for (int k = 0; k < W; k++) step(1'b0, "R3 drain");
    chk(cvState == '0, "R3 drained", cvState, '0);
    randomRun(300, "R4 random A");

    doReset(6'b011111);
    randomRun(300, "R5 random B");

    doReset(6'b000000);
    randomRun(100, "R6 random C");
    chk(cvState == '0, "R6 zero icv keeps empty", cvState, '0);

    summary();
  end

endmodule